// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the column address for each beat of a read or write burst in a synchronous DRAM controller. A command supplies the first column. The generator then steps through the burst according to the burst length and burst type that are in force when the command arrives. Fixed lengths of 1, 2, 4 and 8 words stay inside their aligned block. That block is traversed either sequentially or in interleaved order. In full-page mode the generator walks all 256 columns of the row and keeps going until something stops it.

A burst ends early on a stop input, which covers both a burst-stop command and a precharge. A new command also ends it, because it restarts the generator on the next cycle. Commands may arrive on consecutive cycles. A separate option makes write commands transfer a single word while reads still burst at the programmed length.

The address stream flows out only. It carries a valid strobe and a last-beat flag and has no ready input. The memory cannot stall mid-burst, so the consumer must accept one column on every cycle in which `col_valid` is high. No back-pressure exists.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, `col_valid` and `col_last` are 0 and `col_out` is 0.
- R2: On the cycle after `cmd_start` is sampled high, `col_valid` is 1 and `col_out` equals the `cmd_col` sampled with it. The length, type and write-single settings are captured with the command, and later changes to them do not affect that burst.
- R3: The length code `cfg_len` selects the number of beats: 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8 and 7 gives full page. A fixed-length burst with no interruption presents exactly that many beats on consecutive cycles, and `col_valid` then falls.
- R4: In sequential type (`cfg_interleave`=0), beat k has the low log2(L) bits equal to (start offset + k) mod L. The upper bits are those of the start column.
- R5: In interleaved type (`cfg_interleave`=1), beat k has the low log2(L) bits equal to the start offset XOR k. The upper bits are unchanged.
- R6: In full-page mode each beat is the previous column plus 1, wrapping from 255 to 0. The burst runs without limit until it is stopped or restarted, and `cfg_interleave` has no effect.
- R7: `col_last` is 1 exactly on the final beat of a fixed-length burst and is never 1 in full-page mode.
- R8: `cmd_stop` high without `cmd_start` makes `col_valid` 0 on the next cycle.
- R9: `cmd_start` during an active burst restarts the generator from the new column on the next cycle. It takes priority over `cmd_stop` in the same cycle.
- R10: With `cfg_wr_single`=1, a command with `cmd_write`=1 yields one beat with `col_last`=1, whatever the length code. Read commands keep the programmed length.
- R11: The unused length codes 4, 5 and 6 behave as a one-beat burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_len | input | 3 | Burst length code |
| cfg_interleave | input | 1 | 1 selects interleaved order |
| cfg_wr_single | input | 1 | 1 limits writes to one word |
| cmd_start | input | 1 | Read or write command with column |
| cmd_write | input | 1 | 1 when the command is a write |
| cmd_col | input | 8 | Starting column of the command |
| cmd_stop | input | 1 | Burst stop or precharge |
| col_out | output | 8 | Current column address |
| col_valid | output | 1 | Column on `col_out` is a burst beat |
| col_last | output | 1 | Current beat is the final one |

## Verification
The assertions check the following on every cycle:
- the start column loads one cycle after a command;
- a stop or a final beat drops the strobe;
- an unfinished burst continues;
- `col_last` never appears without `col_valid`;
- sequential bursts always toggle address bit 0;
- full-page bursts step by one;
- a write in single-write mode ends after one beat.

The exact column order of interleaved bursts, wrap at block boundaries, beat counts per length code and immunity to configuration changes mid-burst can only be shown by the bench. It compares every cycle against a reference model under directed and random command streams.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;
  localparam int COL_W = 8;
  localparam logic [2:0] LEN_1    = 3'd0;
  localparam logic [2:0] LEN_2    = 3'd1;
  localparam logic [2:0] LEN_4    = 3'd2;
  localparam logic [2:0] LEN_8    = 3'd3;
  localparam logic [2:0] LEN_PAGE = 3'd7;
endpackage

// File: rtl/burst_len_dec.sv
module burst_len_dec
  import burst_col_pkg::*;
#(
  parameter int W = COL_W
) (
  input  logic [2:0]   len_code,
  input  logic         is_write,
  input  logic         wr_single,
  output logic [W-1:0] blk_mask,
  output logic         page
);
  always_comb begin
    page     = 1'b0;
    blk_mask = '0;
    case (len_code)
      LEN_1:    blk_mask = '0;
      LEN_2:    blk_mask = W'(1);
      LEN_4:    blk_mask = W'(3);
      LEN_8:    blk_mask = W'(7);
      LEN_PAGE: begin
        blk_mask = '1;
        page     = 1'b1;
      end
      default:  blk_mask = '0;
    endcase
    if (is_write && wr_single) begin
      blk_mask = '0;
      page     = 1'b0;
    end
  end
endmodule

// File: rtl/burst_col_step.sv
module burst_col_step
  import burst_col_pkg::*;
#(
  parameter int W = COL_W
) (
  input  logic [W-1:0] base,
  input  logic [W-1:0] beat,
  input  logic [W-1:0] blk_mask,
  input  logic         page,
  input  logic         ilv,
  output logic [W-1:0] col
);
  logic [W-1:0] off0, seq_off, xor_off, sel_off;

  always_comb begin
    off0    = base & blk_mask;
    seq_off = (off0 + beat) & blk_mask;
    xor_off = (off0 ^ beat) & blk_mask;
    sel_off = (ilv && !page) ? xor_off : seq_off;
    col     = (base & ~blk_mask) | sel_off;
  end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_col_pkg::*;
#(
  parameter int W = COL_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [2:0]   cfg_len,
  input  logic         cfg_interleave,
  input  logic         cfg_wr_single,
  input  logic         cmd_start,
  input  logic         cmd_write,
  input  logic [W-1:0] cmd_col,
  input  logic         cmd_stop,
  output logic [W-1:0] col_out,
  output logic         col_valid,
  output logic         col_last
);
  logic         act_q, page_q, il_q;
  logic [W-1:0] base_q, beat_q, mask_q, col_q;
  logic [W-1:0] dec_mask, step_col, beat_nx;
  logic         dec_page, fin;

  burst_len_dec #(.W(W)) u_dec (
    .len_code (cfg_len),
    .is_write (cmd_write),
    .wr_single(cfg_wr_single),
    .blk_mask (dec_mask),
    .page     (dec_page)
  );

  assign beat_nx = beat_q + W'(1);

  burst_col_step #(.W(W)) u_step (
    .base    (base_q),
    .beat    (beat_nx),
    .blk_mask(mask_q),
    .page    (page_q),
    .ilv     (il_q),
    .col     (step_col)
  );

  assign fin = act_q && !page_q && (beat_q == mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      page_q <= 1'b0;
      il_q   <= 1'b0;
      base_q <= '0;
      beat_q <= '0;
      mask_q <= '0;
      col_q  <= '0;
    end else if (cmd_start) begin
      act_q  <= 1'b1;
      page_q <= dec_page;
      il_q   <= cfg_interleave;
      base_q <= cmd_col;
      beat_q <= '0;
      mask_q <= dec_mask;
      col_q  <= cmd_col;
    end else if (cmd_stop) begin
      act_q <= 1'b0;
    end else if (act_q) begin
      if (fin) begin
        act_q <= 1'b0;
      end else begin
        beat_q <= beat_nx;
        col_q  <= step_col;
      end
    end
  end

  assign col_out   = col_q;
  assign col_valid = act_q;
  assign col_last  = fin;
endmodule

// File: rtl/burst_col_gen_chk.sv
module burst_col_gen_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cfg_wr_single,
  input logic         cmd_start,
  input logic         cmd_write,
  input logic [W-1:0] cmd_col,
  input logic         cmd_stop,
  input logic [W-1:0] col_out,
  input logic         col_valid,
  input logic         col_last,
  input logic         il_q,
  input logic         page_q
);
  AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    col_last |-> col_valid); // R7
  AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |=> (col_valid && col_out == $past(cmd_col))); // R2
  AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stop && !cmd_start) |=> !col_valid); // R8
  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (col_last && !cmd_start) |=> !col_valid); // R3
  AST_BURST_CONTINUES: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && !col_last && !cmd_start && !cmd_stop) |=> col_valid); // R3
  AST_SEQ_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && !col_last && !cmd_start && !cmd_stop && (!il_q || page_q))
      |=> (col_out[0] != $past(col_out[0]))); // R4
  AST_PAGE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && page_q && !cmd_start && !cmd_stop)
      |=> (col_out == $past(col_out) + W'(1))); // R6
  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_start && cmd_write && cfg_wr_single) |=> col_last); // R10
endmodule

bind burst_col_gen burst_col_gen_chk #(.W(W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_wr_single(cfg_wr_single),
  .cmd_start    (cmd_start),
  .cmd_write    (cmd_write),
  .cmd_col      (cmd_col),
  .cmd_stop     (cmd_stop),
  .col_out      (col_out),
  .col_valid    (col_valid),
  .col_last     (col_last),
  .il_q         (il_q),
  .page_q       (page_q)
);

// File: tb/burst_col_gen_bench.sv
module burst_col_gen_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] cfg_len = 3'd0;
  logic       cfg_interleave = 1'b0;
  logic       cfg_wr_single = 1'b0;
  logic       cmd_start = 1'b0;
  logic       cmd_write = 1'b0;
  logic [7:0] cmd_col = 8'd0;
  logic       cmd_stop = 1'b0;
  logic [7:0] col_out;
  logic       col_valid, col_last;

  int checks = 0;
  int errors = 0;

  logic       m_act = 1'b0;
  logic [7:0] m_base = 8'd0;
  logic [7:0] m_beat = 8'd0;
  int         m_len = 1;
  logic       m_il = 1'b0;

  always #2.5 clk = ~clk;

  burst_col_gen u_burst_col_gen (
    .clk(clk), .rst_n(rst_n), .cfg_len(cfg_len), .cfg_interleave(cfg_interleave),
    .cfg_wr_single(cfg_wr_single), .cmd_start(cmd_start), .cmd_write(cmd_write),
    .cmd_col(cmd_col), .cmd_stop(cmd_stop), .col_out(col_out),
    .col_valid(col_valid), .col_last(col_last)
  );

  function automatic int len_of(input logic [2:0] code);
    case (code)
      3'd0: return 1;
      3'd1: return 2;
      3'd2: return 4;
      3'd3: return 8;
      3'd7: return 0;
      default: return 1;
    endcase
  endfunction

  function automatic logic [7:0] exp_col();
    logic [7:0] mask, off;
    if (m_len == 0) return m_base + m_beat;
    mask = 8'(m_len - 1);
    off  = m_il ? ((m_base & mask) ^ m_beat) : (((m_base & mask) + m_beat) & mask);
    return (m_base & ~mask) | (off & mask);
  endfunction

  task automatic check(input string tag);
    logic       e_last;
    logic [7:0] e_col;
    string      t;
    e_last = m_act && (m_len != 0) && (m_beat == 8'(m_len - 1));
    e_col  = exp_col();
    t = tag;
    if (t == "") t = (m_len == 0) ? "R6" : (m_il ? "R5" : "R4");
    checks++;
    if (col_valid !== m_act || col_last !== e_last || (m_act && col_out !== e_col)) begin
      errors++;
      $display("FAIL %s: valid=%0b last=%0b col=%0h expected valid=%0b last=%0b col=%0h",
               t, col_valid, col_last, col_out, m_act, e_last, e_col);
    end
  endtask

  task automatic step(input logic s, input logic w, input logic [7:0] c,
                      input logic p, input string tag);
    cmd_start = s; cmd_write = w; cmd_col = c; cmd_stop = p;
    @(posedge clk);
    if (s) begin
      m_act = 1'b1; m_base = c; m_beat = 8'd0; m_il = cfg_interleave;
      m_len = (w && cfg_wr_single) ? 1 : len_of(cfg_len);
    end else if (p) begin
      m_act = 1'b0;
    end else if (m_act) begin
      if (m_len != 0 && m_beat == 8'(m_len - 1)) m_act = 1'b0;
      else m_beat = m_beat + 8'd1;
    end
    @(negedge clk);
    check(tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 8'd0, 1'b0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    checks++;
    if (col_valid !== 1'b0 || col_last !== 1'b0 || col_out !== 8'd0) begin
      errors++;
      $display("FAIL R1: valid=%0b last=%0b col=%0h expected 0 0 0", col_valid, col_last, col_out);
    end
    // R4: length 4 sequential from 0x16 -> 16,17,14,15
    cfg_len = 3'd2; cfg_interleave = 1'b0;
    step(1'b1, 1'b0, 8'h16, 1'b0, "R4"); idle(4, "R4");
    // R5: length 8 interleaved from 0x35
    cfg_len = 3'd3; cfg_interleave = 1'b1;
    step(1'b1, 1'b0, 8'h35, 1'b0, "R5"); idle(8, "R5");
    // R2: settings changed mid-burst are ignored
    cfg_len = 3'd2; cfg_interleave = 1'b0;
    step(1'b1, 1'b0, 8'h42, 1'b0, "R2");
    cfg_len = 3'd3; cfg_interleave = 1'b1;
    idle(5, "R2");
    // R6: full page wraps 255 -> 0, interleave ignored; R8 stop
    cfg_len = 3'd7; cfg_interleave = 1'b1;
    step(1'b1, 1'b0, 8'hFC, 1'b0, "R6"); idle(9, "R6");
    step(1'b0, 1'b0, 8'h00, 1'b1, "R8"); idle(2, "R8");
    // R9: restart mid-burst, start wins over stop
    cfg_len = 3'd3; cfg_interleave = 1'b0;
    step(1'b1, 1'b0, 8'h10, 1'b0, "R9"); idle(2, "R9");
    step(1'b1, 1'b0, 8'h83, 1'b1, "R9"); idle(8, "R9");
    // R10: write single vs read burst
    cfg_wr_single = 1'b1;
    step(1'b1, 1'b1, 8'h20, 1'b0, "R10"); idle(2, "R10");
    step(1'b1, 1'b0, 8'h20, 1'b0, "R10"); idle(8, "R10");
    cfg_wr_single = 1'b0;
    // R11: reserved code acts as single beat
    cfg_len = 3'd5;
    step(1'b1, 1'b0, 8'h77, 1'b0, "R11"); idle(2, "R11");
    // R3 / R7: length 1 and length 2
    cfg_len = 3'd0;
    step(1'b1, 1'b0, 8'h09, 1'b0, "R7"); idle(1, "R3");
    cfg_len = 3'd1;
    step(1'b1, 1'b0, 8'h0B, 1'b0, "R7"); idle(3, "R3");
    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic s, p;
      logic [2:0] lc;
      lc = 3'($urandom_range(0, 7));
      cfg_len = lc;
      cfg_interleave = 1'($urandom);
      cfg_wr_single = ($urandom_range(0, 3) == 0);
      s = ($urandom_range(0, 11) == 0);
      p = ($urandom_range(0, 29) == 0);
      step(s, 1'($urandom), 8'($urandom), p, "");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule